// File: doc/BRIEF.md
# Prefix-Aware CPU Register Bank

This block is the architectural register storage for an 8-bit processor with a two-bank programmer's model. It holds these registers:

- B, C, D, E, H, L, A and F, plus a shadow copy of each.
- Two index pairs and the stack pointer.
- A hidden scratch pair with its own shadow.
- The program counter, the interrupt-vector base, the refresh counter and the interrupt-mode register.

The sequencer drives selector fields straight from instruction bits. A primary 8-bit port and a secondary 8-bit port each take a 3-bit code. A 16-bit pair port takes a 2-bit code and a table bit.

An index-prefix mode input redirects H, L and HL to one of the index pairs. The sequencer holds this input steady for the whole of one instruction. The secondary 8-bit port always sees the plain H and L, which is what an instruction needs when it uses an indexed memory operand and also a true H or L. Whole-pair exchanges, program-counter loads and wrapped up/down stepping complete the interface.

Reads are combinational from the current state. All updates happen on the rising clock edge.

Top module: `cpu_regbank`

## Requirements
- R1: A 16-bit read returns the high register in bits 15:8 and the low register in bits 7:0. A 16-bit write stores bits 15:8 in the high register and bits 7:0 in the low register. Writes land on the rising edge, and reads reflect the current contents.
- R2: The 3-bit register code decodes as 0=B, 1=C, 2=D, 3=E, 4=H, 5=L and 7=A, for both 8-bit ports.
- R3: Code 6 stands for the memory operand. A write with code 6 changes no register, and a read with code 6 returns 0x00.
- R4: Prefix mode 1 maps primary-port codes 4 and 5 to the high and low halves of index pair X, and maps pair code 2 in both tables to X. Mode 2 does the same with index pair Y. Modes 0 and 3 use H, L and HL.
- R5: The secondary 8-bit port ignores the prefix mode, so codes 4 and 5 always reach H and L.
- R6: Pair codes 0, 1 and 2 select BC, DE and HL. Code 3 selects SP when the table bit is 0, and selects AF (A high, F low) when the table bit is 1.
- R7: The exchange opcode selects which pairs swap, whatever the prefix mode. Opcode 0 swaps AF with its shadow. Opcode 1 swaps DE with HL. Opcode 2 swaps BC, DE and HL with their shadows. Opcode 3 swaps the scratch pair with its shadow. Each swap completes in one edge.
- R8: An exchange overrides any write to the same register in that cycle. Otherwise, when several write sources hit the same register, the 16-bit port wins over the primary 8-bit port, which wins over the secondary 8-bit port.
- R9: A clock edge with reset high clears PC, the scratch pair, the interrupt-vector base, the refresh counter and the interrupt mode. It leaves the general registers, the shadows, both index pairs and SP untouched.
- R10: A PC load takes the supplied value. Otherwise a step adds the supplied amount, or subtracts it when the direction bit is 1, modulo 2^16. A load wins over a step.
- R11: The flag outputs expose F as follows: bit 0 carry, bit 1 subtract, bit 2 parity/overflow, bit 3 undocumented X, bit 4 half carry, bit 5 undocumented Y, bit 6 zero and bit 7 sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pfx_mode | input | 2 | Index prefix: 0 none, 1 X, 2 Y, 3 none |
| sel8 | input | 3 | Primary 8-bit register code |
| wr8_en | input | 1 | Primary 8-bit write enable |
| wr8_data | input | 8 | Primary 8-bit write data |
| rd8_data | output | 8 | Primary 8-bit read data |
| sel8r | input | 3 | Secondary (unremapped) 8-bit register code |
| wr8r_en | input | 1 | Secondary 8-bit write enable |
| wr8r_data | input | 8 | Secondary 8-bit write data |
| rd8r_data | output | 8 | Secondary 8-bit read data |
| psel | input | 2 | Pair code |
| ptab | input | 1 | Pair table: 0 ends in SP, 1 ends in AF |
| wr16_en | input | 1 | Pair write enable |
| wr16_data | input | 16 | Pair write data |
| rd16_data | output | 16 | Pair read data |
| xchg_en | input | 1 | Exchange strobe |
| xchg_op | input | 2 | Exchange selection |
| pc_ld | input | 1 | PC load |
| pc_din | input | 16 | PC load value |
| pc_step | input | 1 | PC step strobe |
| pc_down | input | 1 | Step direction: 1 subtracts |
| pc_amt | input | 16 | Step amount |
| pc_q | output | 16 | Program counter |
| wz_wr | input | 1 | Scratch pair write |
| wz_din | input | 16 | Scratch pair write value |
| wz_q | output | 16 | Scratch pair |
| ivec_wr | input | 1 | Interrupt-vector base write |
| ivec_din | input | 8 | Interrupt-vector base value |
| ivec_q | output | 8 | Interrupt-vector base |
| rfsh_wr | input | 1 | Refresh counter write |
| rfsh_din | input | 8 | Refresh counter value |
| rfsh_q | output | 8 | Refresh counter |
| imode_wr | input | 1 | Interrupt mode write |
| imode_din | input | 2 | Interrupt mode value |
| imode_q | output | 2 | Interrupt mode |
| fl_carry | output | 1 | F bit 0 |
| fl_sub | output | 1 | F bit 1 |
| fl_pv | output | 1 | F bit 2 |
| fl_x | output | 1 | F bit 3 |
| fl_half | output | 1 | F bit 4 |
| fl_y | output | 1 | F bit 5 |
| fl_zero | output | 1 | F bit 6 |
| fl_sign | output | 1 | F bit 7 |

## Verification
The assertions assume that reset is synchronous and is seen on a clock edge. They also assume that the sequencer keeps the selector inputs stable between edges. The check that a code-6 write leaves the registers alone applies only in cycles with no other write source and no exchange, so it never has to untangle overlapping updates. The stimulus changes inputs only a short delay after each rising edge, raises one write source at a time except in the cycles that test priority, and keeps write strobes low while reset is high.

// File: rtl/cpu_regbank.sv
module cpu_regbank (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  pfx_mode,
  input  logic [2:0]  sel8,
  input  logic        wr8_en,
  input  logic [7:0]  wr8_data,
  output logic [7:0]  rd8_data,
  input  logic [2:0]  sel8r,
  input  logic        wr8r_en,
  input  logic [7:0]  wr8r_data,
  output logic [7:0]  rd8r_data,
  input  logic [1:0]  psel,
  input  logic        ptab,
  input  logic        wr16_en,
  input  logic [15:0] wr16_data,
  output logic [15:0] rd16_data,
  input  logic        xchg_en,
  input  logic [1:0]  xchg_op,
  input  logic        pc_ld,
  input  logic [15:0] pc_din,
  input  logic        pc_step,
  input  logic        pc_down,
  input  logic [15:0] pc_amt,
  output logic [15:0] pc_q,
  input  logic        wz_wr,
  input  logic [15:0] wz_din,
  output logic [15:0] wz_q,
  input  logic        ivec_wr,
  input  logic [7:0]  ivec_din,
  output logic [7:0]  ivec_q,
  input  logic        rfsh_wr,
  input  logic [7:0]  rfsh_din,
  output logic [7:0]  rfsh_q,
  input  logic        imode_wr,
  input  logic [1:0]  imode_din,
  output logic [1:0]  imode_q,
  output logic        fl_carry,
  output logic        fl_sub,
  output logic        fl_pv,
  output logic        fl_x,
  output logic        fl_half,
  output logic        fl_y,
  output logic        fl_zero,
  output logic        fl_sign
);
  localparam int DW   = 8;
  localparam int RB   = 0;
  localparam int RD   = 2;
  localparam int RH   = 4;
  localparam int RA   = 6;
  localparam int RF   = 7;
  localparam int SH   = 8;
  localparam int IXH  = 16;
  localparam int IYH  = 18;
  localparam int SPH  = 20;
  localparam int WZH  = 22;
  localparam int WZSH = 24;
  localparam int NREG = 26;
  localparam int IW   = $clog2(NREG);
  localparam logic [2:0] MEM_CODE = 3'd6;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] nxt  [NREG];
  logic [NREG*DW-1:0] flat;

  function automatic logic [IW-1:0] hl_base(input logic [1:0] m);
    case (m)
      2'd1:    hl_base = IW'(IXH);
      2'd2:    hl_base = IW'(IYH);
      default: hl_base = IW'(RH);
    endcase
  endfunction

  function automatic logic [IW-1:0] map8(input logic [2:0] c, input logic [1:0] m);
    case (c)
      3'd4:    map8 = hl_base(m);
      3'd5:    map8 = hl_base(m) + IW'(1);
      3'd7:    map8 = IW'(RA);
      3'd6:    map8 = '0;
      default: map8 = IW'(c);
    endcase
  endfunction

  function automatic logic [IW-1:0] mapp(input logic [1:0] c, input logic t, input logic [1:0] m);
    case (c)
      2'd0:    mapp = IW'(RB);
      2'd1:    mapp = IW'(RD);
      2'd2:    mapp = hl_base(m);
      default: mapp = t ? IW'(RA) : IW'(SPH);
    endcase
  endfunction

  logic [IW-1:0] i8, i8r, iph, ipl;
  logic          v8, v8r;

  assign i8  = map8(sel8, pfx_mode);
  assign i8r = map8(sel8r, 2'd0);
  assign v8  = (sel8 != MEM_CODE);
  assign v8r = (sel8r != MEM_CODE);
  assign iph = mapp(psel, ptab, pfx_mode);
  assign ipl = iph + IW'(1);

  assign rd8_data  = v8  ? regs[i8]  : '0;
  assign rd8r_data = v8r ? regs[i8r] : '0;
  assign rd16_data = {regs[iph], regs[ipl]};
  assign wz_q      = {regs[WZH], regs[WZH+1]};
  assign {fl_sign, fl_zero, fl_y, fl_half, fl_x, fl_pv, fl_sub, fl_carry} = regs[RF];

  always_comb begin
    nxt = regs;
    if (wr8r_en && v8r) nxt[i8r] = wr8r_data;
    if (wr8_en && v8)   nxt[i8]  = wr8_data;
    if (wr16_en) begin
      nxt[iph] = wr16_data[15:8];
      nxt[ipl] = wr16_data[7:0];
    end
    if (wz_wr) begin
      nxt[WZH]   = wz_din[15:8];
      nxt[WZH+1] = wz_din[7:0];
    end
    if (xchg_en) begin
      case (xchg_op)
        2'd0: begin
          nxt[RA] = regs[RA+SH];  nxt[RA+SH] = regs[RA];
          nxt[RF] = regs[RF+SH];  nxt[RF+SH] = regs[RF];
        end
        2'd1: begin
          nxt[RD]   = regs[RH];   nxt[RH]   = regs[RD];
          nxt[RD+1] = regs[RH+1]; nxt[RH+1] = regs[RD+1];
        end
        2'd2: begin
          for (int k = 0; k < 6; k++) begin
            nxt[k]    = regs[k+SH];
            nxt[k+SH] = regs[k];
          end
        end
        default: begin
          nxt[WZH]   = regs[WZSH];   nxt[WZSH]   = regs[WZH];
          nxt[WZH+1] = regs[WZSH+1]; nxt[WZSH+1] = regs[WZH+1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    regs <= nxt;
    if (rst) begin
      regs[WZH]   <= '0;
      regs[WZH+1] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      ivec_q  <= '0;
      rfsh_q  <= '0;
      imode_q <= '0;
    end else begin
      if (pc_ld)        pc_q <= pc_din;
      else if (pc_step) pc_q <= pc_down ? pc_q - pc_amt : pc_q + pc_amt;
      if (ivec_wr)  ivec_q  <= ivec_din;
      if (rfsh_wr)  rfsh_q  <= rfsh_din;
      if (imode_wr) imode_q <= imode_din;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat[g*DW +: DW] = regs[g];
  end

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == 16'h0 && wz_q == 16'h0 && ivec_q == 8'h0 && rfsh_q == 8'h0 && imode_q == 2'd0));

  // R10
  pc_up_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_step && !pc_ld && !pc_down) |=> (pc_q == 16'($past(pc_q) + $past(pc_amt))));

  // R10
  pc_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_step && !pc_ld && pc_down) |=> (pc_q == 16'($past(pc_q) - $past(pc_amt))));

  // R3
  mem_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr8_en && sel8 == MEM_CODE && !wr8r_en && !wr16_en && !xchg_en && !wz_wr) |=> $stable(flat));

  // R7
  xchg_af_chk: assert property (@(posedge clk) disable iff (rst)
    (xchg_en && xchg_op == 2'd0) |=> ({regs[RA], regs[RF]} == $past({regs[RA+SH], regs[RF+SH]})));

  // R8
  xchg_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (xchg_en && xchg_op == 2'd1 && wr16_en) |=> ({regs[RD], regs[RD+1]} == $past({regs[RH], regs[RH+1]})));

  // R5
  raw_port_chk: assert property (@(posedge clk) disable iff (rst)
    (sel8r == sel8 && (pfx_mode == 2'd0 || pfx_mode == 2'd3)) |-> (rd8r_data == rd8_data));
endmodule

// File: tb/tb_cpu_regbank.sv
module tb_cpu_regbank;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pfx_mode = '0;
  logic [2:0] sel8 = '0, sel8r = '0;
  logic wr8_en = 0, wr8r_en = 0, wr16_en = 0, xchg_en = 0;
  logic [7:0] wr8_data = '0, wr8r_data = '0;
  logic [1:0] psel = '0, xchg_op = '0;
  logic ptab = 0;
  logic [15:0] wr16_data = '0;
  logic pc_ld = 0, pc_step = 0, pc_down = 0, wz_wr = 0;
  logic [15:0] pc_din = '0, pc_amt = '0, wz_din = '0;
  logic ivec_wr = 0, rfsh_wr = 0, imode_wr = 0;
  logic [7:0] ivec_din = '0, rfsh_din = '0;
  logic [1:0] imode_din = '0;
  logic [7:0] rd8_data, rd8r_data, ivec_q, rfsh_q;
  logic [15:0] rd16_data, pc_q, wz_q;
  logic [1:0] imode_q;
  logic fl_carry, fl_sub, fl_pv, fl_x, fl_half, fl_y, fl_zero, fl_sign;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cpu_regbank dut (
    .clk(clk), .rst(rst), .pfx_mode(pfx_mode),
    .sel8(sel8), .wr8_en(wr8_en), .wr8_data(wr8_data), .rd8_data(rd8_data),
    .sel8r(sel8r), .wr8r_en(wr8r_en), .wr8r_data(wr8r_data), .rd8r_data(rd8r_data),
    .psel(psel), .ptab(ptab), .wr16_en(wr16_en), .wr16_data(wr16_data), .rd16_data(rd16_data),
    .xchg_en(xchg_en), .xchg_op(xchg_op),
    .pc_ld(pc_ld), .pc_din(pc_din), .pc_step(pc_step), .pc_down(pc_down), .pc_amt(pc_amt), .pc_q(pc_q),
    .wz_wr(wz_wr), .wz_din(wz_din), .wz_q(wz_q),
    .ivec_wr(ivec_wr), .ivec_din(ivec_din), .ivec_q(ivec_q),
    .rfsh_wr(rfsh_wr), .rfsh_din(rfsh_din), .rfsh_q(rfsh_q),
    .imode_wr(imode_wr), .imode_din(imode_din), .imode_q(imode_q),
    .fl_carry(fl_carry), .fl_sub(fl_sub), .fl_pv(fl_pv), .fl_x(fl_x),
    .fl_half(fl_half), .fl_y(fl_y), .fl_zero(fl_zero), .fl_sign(fl_sign)
  );

  // {wpfx[2], wcode[3], wdata[8], raw[1], rpfx[2], rcode[3], exp[8]}
  localparam logic [26:0] VEC [13] = '{
    {2'd0, 3'd0, 8'h11, 1'b0, 2'd0, 3'd0, 8'h11},
    {2'd0, 3'd1, 8'h22, 1'b1, 2'd0, 3'd1, 8'h22},
    {2'd0, 3'd2, 8'h33, 1'b0, 2'd0, 3'd2, 8'h33},
    {2'd0, 3'd3, 8'h44, 1'b1, 2'd0, 3'd3, 8'h44},
    {2'd0, 3'd4, 8'h55, 1'b1, 2'd0, 3'd4, 8'h55},
    {2'd0, 3'd5, 8'h66, 1'b0, 2'd0, 3'd5, 8'h66},
    {2'd0, 3'd7, 8'h77, 1'b0, 2'd0, 3'd7, 8'h77},
    {2'd1, 3'd4, 8'hA1, 1'b1, 2'd1, 3'd4, 8'h55},
    {2'd1, 3'd5, 8'hA2, 1'b0, 2'd1, 3'd5, 8'hA2},
    {2'd2, 3'd4, 8'hB1, 1'b0, 2'd2, 3'd4, 8'hB1},
    {2'd2, 3'd5, 8'hB2, 1'b0, 2'd1, 3'd5, 8'hA2},
    {2'd0, 3'd6, 8'hFF, 1'b0, 2'd0, 3'd6, 8'h00},
    {2'd1, 3'd6, 8'hEE, 1'b1, 2'd1, 3'd4, 8'h55}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    wr8_en = 0; wr8r_en = 0; wr16_en = 0; xchg_en = 0;
    pc_ld = 0; pc_step = 0; wz_wr = 0; ivec_wr = 0; rfsh_wr = 0; imode_wr = 0;
  endtask

  task automatic wpair(input logic t, input logic [1:0] c, input logic [15:0] d);
    ptab = t; psel = c; wr16_data = d; wr16_en = 1; step();
  endtask

  task automatic rpair(input string tag, input logic t, input logic [1:0] c, input logic [15:0] e);
    ptab = t; psel = c; #1; chk(tag, rd16_data, e);
  endtask

  task automatic xchg(input logic [1:0] op);
    xchg_op = op; xchg_en = 1; step();
  endtask

  task automatic chk_flags(input string tag, input logic [7:0] e);
    chk({tag, " carry"}, 16'(fl_carry), 16'(e[0]));
    chk({tag, " sub"},   16'(fl_sub),   16'(e[1]));
    chk({tag, " pv"},    16'(fl_pv),    16'(e[2]));
    chk({tag, " x"},     16'(fl_x),     16'(e[3]));
    chk({tag, " half"},  16'(fl_half),  16'(e[4]));
    chk({tag, " y"},     16'(fl_y),     16'(e[5]));
    chk({tag, " zero"},  16'(fl_zero),  16'(e[6]));
    chk({tag, " sign"},  16'(fl_sign),  16'(e[7]));
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    chk("R9 reset pc", pc_q, 16'h0);
    chk("R9 reset wz", wz_q, 16'h0);
    chk("R9 reset ivec", 16'(ivec_q), 16'h0);
    chk("R9 reset rfsh", 16'(rfsh_q), 16'h0);
    chk("R9 reset imode", 16'(imode_q), 16'h0);
    rst = 0;

    for (int n = 0; n < 13; n++) begin
      pfx_mode = VEC[n][26:25]; sel8 = VEC[n][24:22]; wr8_data = VEC[n][21:14]; wr8_en = 1;
      step();
      pfx_mode = VEC[n][12:11];
      if (VEC[n][13]) begin
        sel8r = VEC[n][10:8]; #1; chk("R2 R3 R4 R5 vec raw", 16'(rd8r_data), 16'(VEC[n][7:0]));
      end else begin
        sel8 = VEC[n][10:8]; #1; chk("R2 R3 R4 R5 vec pri", 16'(rd8_data), 16'(VEC[n][7:0]));
      end
    end

    pfx_mode = 2'd0;
    rpair("R1 R6 BC", 0, 2'd0, 16'h1122);
    rpair("R1 R6 DE", 0, 2'd1, 16'h3344);
    rpair("R1 R6 HL", 1, 2'd2, 16'h5566);
    pfx_mode = 2'd1; rpair("R4 X pair t0", 0, 2'd2, 16'hA1A2);
    rpair("R4 X pair t1", 1, 2'd2, 16'hA1A2);
    pfx_mode = 2'd2; rpair("R4 Y pair", 0, 2'd2, 16'hB1B2);
    pfx_mode = 2'd3; rpair("R4 mode3 HL", 0, 2'd2, 16'h5566);

    pfx_mode = 2'd1; wpair(1, 2'd2, 16'hC3D4);
    sel8r = 3'd4; sel8 = 3'd4; #1;
    chk("R5 raw H after X write", 16'(rd8r_data), 16'h55);
    chk("R4 X high via primary", 16'(rd8_data), 16'hC3);
    pfx_mode = 2'd2; rpair("R4 Y untouched", 1, 2'd2, 16'hB1B2);

    pfx_mode = 2'd0;
    wpair(0, 2'd3, 16'hFFFE);
    rpair("R6 SP", 0, 2'd3, 16'hFFFE);
    wpair(1, 2'd3, 16'h12C5);
    rpair("R6 AF", 1, 2'd3, 16'h12C5);
    rpair("R6 SP kept", 0, 2'd3, 16'hFFFE);
    sel8 = 3'd7; #1; chk("R1 A from AF", 16'(rd8_data), 16'h12);
    chk_flags("R11 C5", 8'hC5);
    wpair(1, 2'd3, 16'h123A);
    chk_flags("R11 3A", 8'h3A);

    xchg(2'd0);
    wpair(1, 2'd3, 16'h3344);
    xchg(2'd0);
    rpair("R7 AF swap back", 1, 2'd3, 16'h123A);
    xchg(2'd0);
    rpair("R7 AF swap again", 1, 2'd3, 16'h3344);

    ptab = 1; psel = 2'd3; wr16_data = 16'h9999; wr16_en = 1; xchg_op = 2'd0; xchg_en = 1; step();
    rpair("R8 exchange beats write", 1, 2'd3, 16'h123A);
    xchg(2'd0);
    rpair("R8 write dropped", 1, 2'd3, 16'h3344);

    xchg(2'd1);
    rpair("R7 DE<-HL", 0, 2'd1, 16'h5566);
    rpair("R7 HL<-DE", 0, 2'd2, 16'h3344);
    pfx_mode = 2'd1; xchg(2'd1);
    pfx_mode = 2'd0; rpair("R7 prefixed swap uses HL", 0, 2'd2, 16'h5566);
    pfx_mode = 2'd1; rpair("R7 X untouched by swap", 0, 2'd2, 16'hC3D4);
    pfx_mode = 2'd0;

    xchg(2'd2);
    wpair(0, 2'd0, 16'hAAAA);
    xchg(2'd2);
    rpair("R7 bank BC", 0, 2'd0, 16'h1122);
    rpair("R7 bank DE", 0, 2'd1, 16'h3344);
    xchg(2'd2);
    rpair("R7 bank BC alt", 0, 2'd0, 16'hAAAA);
    xchg(2'd2);

    wz_din = 16'h0F0F; wz_wr = 1; step();
    xchg(2'd3);
    wz_din = 16'hF0F0; wz_wr = 1; step();
    chk("R7 wz written", wz_q, 16'hF0F0);
    xchg(2'd3);
    chk("R7 wz swap", wz_q, 16'h0F0F);

    sel8r = 3'd4; wr8r_data = 8'h01; wr8r_en = 1;
    sel8 = 3'd4; wr8_data = 8'h02; wr8_en = 1; step();
    sel8r = 3'd4; #1; chk("R8 primary beats secondary", 16'(rd8r_data), 16'h02);
    sel8r = 3'd5; wr8r_data = 8'h03; wr8r_en = 1;
    sel8 = 3'd4; wr8_data = 8'h04; wr8_en = 1;
    ptab = 0; psel = 2'd2; wr16_data = 16'h7788; wr16_en = 1; step();
    rpair("R8 pair beats bytes", 0, 2'd2, 16'h7788);

    pc_din = 16'h0010; pc_ld = 1; step();
    chk("R10 load", pc_q, 16'h0010);
    pc_amt = 16'd3; pc_down = 0; pc_step = 1; step();
    chk("R10 up", pc_q, 16'h0013);
    pc_amt = 16'h0014; pc_down = 1; pc_step = 1; step();
    chk("R10 down wrap", pc_q, 16'hFFFF);
    pc_amt = 16'd1; pc_down = 0; pc_step = 1; step();
    chk("R10 up wrap", pc_q, 16'h0000);
    pc_din = 16'h8000; pc_ld = 1; pc_amt = 16'd5; pc_step = 1; step();
    chk("R10 load wins", pc_q, 16'h8000);

    ivec_din = 8'h5A; ivec_wr = 1; rfsh_din = 8'hA5; rfsh_wr = 1; imode_din = 2'd2; imode_wr = 1;
    wz_din = 16'hBEEF; wz_wr = 1; step();
    chk("R9 ivec set", 16'(ivec_q), 16'h5A);
    chk("R9 imode set", 16'(imode_q), 16'h2);
    rst = 1; step(); rst = 0;
    chk("R9 pc cleared", pc_q, 16'h0);
    chk("R9 wz cleared", wz_q, 16'h0);
    chk("R9 ivec cleared", 16'(ivec_q), 16'h0);
    chk("R9 rfsh cleared", 16'(rfsh_q), 16'h0);
    chk("R9 imode cleared", 16'(imode_q), 16'h0);
    rpair("R9 BC kept", 0, 2'd0, 16'h1122);
    rpair("R9 SP kept", 0, 2'd3, 16'hFFFE);
    rpair("R9 AF kept", 1, 2'd3, 16'h3344);
    pfx_mode = 2'd1; rpair("R9 X kept", 0, 2'd2, 16'hC3D4);
    pfx_mode = 2'd0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule